// File: doc/BRIEF.md
# Serial Voltage-Code Send-Byte Receiver

This block listens on a two-wire serial bus that uses fast-mode I2C signalling. A host processor uses the bus to set the supply voltage codes of a dual-output regulator. The block samples the serial clock and data lines in a fast local clock domain. It receives an address byte and then a data byte. It pulls the data line low only to acknowledge. It never drives the serial clock.

The block knows three addresses. In each of them, address bits 4:3 are don't-care. The address decides whether the new 7-bit voltage code goes to output A, to output B or to both. The most significant bit of the data byte is an active-low power-state flag, and the block copies it to a registered output. One code value, set by a parameter, means "turn off". When that code arrives, the block raises an off flag and leaves both voltage codes as they are.

Before power-good goes high, both outputs follow a 2-bit boot code and the bus is ignored. After power-good goes high, the outputs hold their value until a serial command arrives.

Top module: `svid_sendbyte_slave`

## Requirements
- R1: Bus activity before a start condition is ignored. A start condition is a falling data line while the serial clock is high. Clocked bytes sent without a start get no acknowledge and change no output.
- R2: The address byte is received MSB first, with the write bit (must be 0) as its last bit. Pattern 110xx100 routes the code to both outputs A and B.
- R3: Pattern 110xx010 updates only output A, and 110xx110 updates only output B. Address bits 4:3 (x) may take any value, and the output that is not selected keeps its value.
- R4: On a matching address or a received data byte, the block pulls the data line low (data output-enable = 1) during the ninth serial clock. It releases the line after that clock's falling edge.
- R5: A non-matching address byte, including one with the write bit set to 1, gets no acknowledge. The data byte that follows is ignored, and the outputs stay unchanged.
- R6: In the data byte, bit 7 drives the power-state output (active low) and bits 6:0 are the voltage code. The selected outputs take the new code after the eighth data bit.
- R7: A data code equal to OFF_CODE (default 7'h7C) sets the off flag and leaves both voltage codes unchanged. Any other accepted data byte clears the off flag.
- R8: While power-good is low, both voltage codes equal the 2-bit boot input zero-extended to 7 bits, the power-state output is 1 and the off flag is 0. The bus is ignored and gets no acknowledge. Once power-good is high, changes on the boot input have no effect.
- R9: A stop condition (data line rising while the clock is high) or a start condition in the middle of a transaction aborts it. The block returns to idle without updating anything. Bytes that follow without a fresh start are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local system clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk_i | input | 1 | Serial bus clock line (input only) |
| ser_dat_i | input | 1 | Serial bus data line as seen on the wire |
| ser_dat_oe_o | output | 1 | Pull data line low when 1 (acknowledge) |
| pwr_good_i | input | 1 | Power-good; low keeps boot mode |
| boot_code_i | input | 2 | Boot voltage code used before power-good |
| code_a_o | output | 7 | Registered voltage code, output A |
| code_b_o | output | 7 | Registered voltage code, output B |
| psi_n_o | output | 1 | Registered active-low power-state flag |
| vid_off_o | output | 1 | Registered off flag |

## Verification
Each bus line takes three local clock edges to pass through its synchroniser and edge stage. The acknowledge enable therefore rises on the third edge after a falling serial clock, and the register bank takes a new command one edge after that. The bench holds each serial clock phase for eight local cycles. It samples the acknowledge four cycles into the high phase of the ninth clock and checks the release four cycles after that clock falls. The scoreboard compares the four output fields only after the stop condition has been held for eight cycles, well past the four-edge update latency.

// File: rtl/svid_pkg.sv
package svid_pkg;
    localparam int BYTE_BITS = 8;
    localparam int CODE_W    = BYTE_BITS - 1;
    localparam int CNT_W     = $clog2(BYTE_BITS + 1);
    localparam int BOOT_W    = 2;

    typedef enum logic [1:0] {RT_NONE, RT_A, RT_B, RT_BOTH} route_e;

    typedef enum logic [2:0] {RX_IDLE, RX_ADDR, RX_AACK, RX_DATA, RX_DACK} rx_state_e;

    typedef struct packed {
        logic lvl;
        logic rise;
        logic fall;
    } line_t;

    typedef struct packed {
        route_e              route;
        logic                psi_n;
        logic [CODE_W-1:0]   code;
    } cmd_t;

    // Address byte (with write bit in bit 0) to output routing
    function automatic route_e decode_addr(input logic [BYTE_BITS-1:0] b);
        if (b[7:5] != 3'b110) return RT_NONE;
        case (b[2:0])
            3'b100:  return RT_BOTH;
            3'b010:  return RT_A;
            3'b110:  return RT_B;
            default: return RT_NONE;
        endcase
    endfunction

    function automatic logic [CODE_W-1:0] boot_to_code(input logic [BOOT_W-1:0] b);
        return {{(CODE_W-BOOT_W){1'b0}}, b};
    endfunction
endpackage

// File: rtl/svid_line_sync.sv
module svid_line_sync
    import svid_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  din,
    output line_t q
);
    // chain[STAGES-1] is the synchronised level, chain[STAGES] its previous value
    logic [STAGES:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-1:0], din};
    end

    always_comb begin
        q.lvl  = chain[STAGES-1];
        q.rise = chain[STAGES-1] & ~chain[STAGES];
        q.fall = ~chain[STAGES-1] & chain[STAGES];
    end
endmodule

// File: rtl/svid_byte_rx.sv
module svid_byte_rx
    import svid_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  pwr_good,
    input  line_t scl,
    input  line_t sda,
    output logic  ack_oe,
    output logic  cmd_valid,
    output cmd_t  cmd
);
    rx_state_e             state;
    logic [BYTE_BITS-1:0]  shreg;
    logic [CNT_W-1:0]      cnt;
    route_e                route_q;
    logic                  start_c, stop_c, full;

    assign start_c = scl.lvl & ~scl.rise & sda.fall;
    assign stop_c  = scl.lvl & ~scl.rise & sda.rise;
    assign full    = (cnt == CNT_W'(BYTE_BITS));

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= RX_IDLE;
            shreg     <= '0;
            cnt       <= '0;
            route_q   <= RT_NONE;
            ack_oe    <= 1'b0;
            cmd_valid <= 1'b0;
            cmd       <= '0;
        end else begin
            cmd_valid <= 1'b0;
            if (!pwr_good) begin
                state  <= RX_IDLE;
                ack_oe <= 1'b0;
                cnt    <= '0;
            end else if (start_c || stop_c) begin
                // only a start seen from idle opens a transaction
                state  <= (state == RX_IDLE && start_c) ? RX_ADDR : RX_IDLE;
                ack_oe <= 1'b0;
                cnt    <= '0;
            end else begin
                case (state)
                    RX_ADDR, RX_DATA: begin
                        if (scl.rise && !full) begin
                            shreg <= {shreg[BYTE_BITS-2:0], sda.lvl};
                            cnt   <= cnt + 1'b1;
                        end else if (scl.fall && full) begin
                            cnt <= '0;
                            if (state == RX_ADDR) begin
                                if (decode_addr(shreg) != RT_NONE) begin
                                    route_q <= decode_addr(shreg);
                                    state   <= RX_AACK;
                                    ack_oe  <= 1'b1;
                                end else begin
                                    state <= RX_IDLE;
                                end
                            end else begin
                                cmd_valid <= 1'b1;
                                cmd       <= '{route: route_q,
                                               psi_n: shreg[BYTE_BITS-1],
                                               code:  shreg[CODE_W-1:0]};
                                state     <= RX_DACK;
                                ack_oe    <= 1'b1;
                            end
                        end
                    end
                    RX_AACK: if (scl.fall) begin
                        ack_oe <= 1'b0;
                        state  <= RX_DATA;
                    end
                    RX_DACK: if (scl.fall) begin
                        ack_oe <= 1'b0;
                        state  <= RX_IDLE;
                    end
                    default: ;
                endcase
            end
        end
    end

    // R4
    ack_rise_low_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ack_oe) |-> !scl.lvl);

    // R5
    cmd_route_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> cmd.route != RT_NONE);

    // R8
    boot_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !pwr_good |=> !ack_oe && !cmd_valid);

    // R9
    stop_abort_chk: assert property (@(posedge clk) disable iff (rst)
        stop_c |=> !ack_oe && !cmd_valid);
endmodule

// File: rtl/svid_vcode_regs.sv
module svid_vcode_regs
    import svid_pkg::*;
#(
    parameter logic [CODE_W-1:0] OFF_CODE = 7'h7C
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pwr_good,
    input  logic [BOOT_W-1:0] boot_code,
    input  logic              cmd_valid,
    input  cmd_t              cmd,
    output logic [CODE_W-1:0] code_a,
    output logic [CODE_W-1:0] code_b,
    output logic              psi_n,
    output logic              vid_off
);
    logic sel_a, sel_b;
    assign sel_a = (cmd.route == RT_A) || (cmd.route == RT_BOTH);
    assign sel_b = (cmd.route == RT_B) || (cmd.route == RT_BOTH);

    always_ff @(posedge clk) begin
        if (rst) begin
            code_a  <= '0;
            code_b  <= '0;
            psi_n   <= 1'b1;
            vid_off <= 1'b0;
        end else if (!pwr_good) begin
            code_a  <= boot_to_code(boot_code);
            code_b  <= boot_to_code(boot_code);
            psi_n   <= 1'b1;
            vid_off <= 1'b0;
        end else if (cmd_valid) begin
            psi_n <= cmd.psi_n;
            if (cmd.code == OFF_CODE) begin
                vid_off <= 1'b1;
            end else begin
                vid_off <= 1'b0;
                if (sel_a) code_a <= cmd.code;
                if (sel_b) code_b <= cmd.code;
            end
        end
    end

    // R7
    off_hold_chk: assert property (@(posedge clk) disable iff (rst)
        pwr_good && cmd_valid && cmd.code == OFF_CODE
        |=> $stable(code_a) && $stable(code_b) && vid_off);

    // R8
    boot_follow_chk: assert property (@(posedge clk) disable iff (rst)
        !pwr_good |=> code_a == boot_to_code($past(boot_code)) && !vid_off && psi_n);

    // R3
    route_a_only_chk: assert property (@(posedge clk) disable iff (rst)
        pwr_good && cmd_valid && cmd.route == RT_A |=> $stable(code_b));
endmodule

// File: rtl/svid_sendbyte_slave.sv
module svid_sendbyte_slave
    import svid_pkg::*;
#(
    parameter int                SYNC_STAGES = 2,
    parameter logic [CODE_W-1:0] OFF_CODE    = 7'h7C
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ser_clk_i,
    input  logic              ser_dat_i,
    output logic              ser_dat_oe_o,
    input  logic              pwr_good_i,
    input  logic [BOOT_W-1:0] boot_code_i,
    output logic [CODE_W-1:0] code_a_o,
    output logic [CODE_W-1:0] code_b_o,
    output logic              psi_n_o,
    output logic              vid_off_o
);
    line_t scl_q, sda_q;
    logic  cmd_valid;
    cmd_t  cmd;

    svid_line_sync #(.STAGES(SYNC_STAGES)) u_sync_clk (
        .clk(clk), .rst(rst), .din(ser_clk_i), .q(scl_q)
    );

    svid_line_sync #(.STAGES(SYNC_STAGES)) u_sync_dat (
        .clk(clk), .rst(rst), .din(ser_dat_i), .q(sda_q)
    );

    svid_byte_rx u_rx (
        .clk(clk), .rst(rst), .pwr_good(pwr_good_i),
        .scl(scl_q), .sda(sda_q),
        .ack_oe(ser_dat_oe_o), .cmd_valid(cmd_valid), .cmd(cmd)
    );

    svid_vcode_regs #(.OFF_CODE(OFF_CODE)) u_regs (
        .clk(clk), .rst(rst), .pwr_good(pwr_good_i), .boot_code(boot_code_i),
        .cmd_valid(cmd_valid), .cmd(cmd),
        .code_a(code_a_o), .code_b(code_b_o), .psi_n(psi_n_o), .vid_off(vid_off_o)
    );

    // R4
    ack_only_busy_chk: assert property (@(posedge clk) disable iff (rst)
        ser_dat_oe_o |-> pwr_good_i);
endmodule

// File: tb/svid_sendbyte_slave_tb.sv
module svid_sendbyte_slave_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       pg = 1'b0;
    logic [1:0] boot = 2'b10;
    logic       oe;
    logic [6:0] code_a, code_b;
    logic       psi_n, voff;
    wire        sda_line = sda_m & ~oe;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [6:0] a;
        logic [6:0] b;
        logic       psi_n;
        logic       off;
        string      req;
    } exp_t;

    exp_t exp_q[$];
    event txn_done;

    // expected state kept by the bench
    logic [6:0] m_a = 7'd2, m_b = 7'd2;
    logic       m_psi = 1'b1, m_off = 1'b0;

    always #10 clk = ~clk;

    svid_sendbyte_slave u_dut (
        .clk(clk), .rst(rst), .ser_clk_i(scl_m), .ser_dat_i(sda_line),
        .ser_dat_oe_o(oe), .pwr_good_i(pg), .boot_code_i(boot),
        .code_a_o(code_a), .code_b_o(code_b), .psi_n_o(psi_n), .vid_off_o(voff)
    );

    task automatic wait_clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic push_state(input string req);
        exp_t e;
        e.a = m_a; e.b = m_b; e.psi_n = m_psi; e.off = m_off; e.req = req;
        exp_q.push_back(e);
        -> txn_done;
        wait_clks(4);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wait_clks(2);
        scl_m = 1'b1; wait_clks(4);
        sda_m = 1'b0; wait_clks(6);
        scl_m = 1'b0; wait_clks(4);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_clks(4);
        scl_m = 1'b1; wait_clks(6);
        sda_m = 1'b1; wait_clks(8);
    endtask

    task automatic put_bit(input logic b);
        sda_m = b;    wait_clks(4);
        scl_m = 1'b1; wait_clks(8);
        scl_m = 1'b0; wait_clks(4);
    endtask

    // ninth clock: master releases, samples the wire, then checks release
    task automatic ack_slot(input string req, input logic exp_ack);
        logic got;
        sda_m = 1'b1; wait_clks(4);
        scl_m = 1'b1; wait_clks(4);
        got = ~sda_line;
        chk(req, "acknowledge", got, exp_ack);
        wait_clks(4);
        scl_m = 1'b0; wait_clks(4);
        chk("R4", "data line released after ninth clock", oe, 1'b0);
    endtask

    task automatic put_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) put_bit(b[i]);
    endtask

    function automatic logic addr_ok(input logic [7:0] a);
        return (a[7:5] == 3'b110) &&
               (a[2:0] == 3'b100 || a[2:0] == 3'b010 || a[2:0] == 3'b110);
    endfunction

    task automatic send_txn(input logic [7:0] addr, input logic [7:0] data,
                            input string req);
        logic hit;
        hit = addr_ok(addr) && pg;
        bus_start();
        put_byte(addr);
        ack_slot(req, hit);
        put_byte(data);
        ack_slot(req, hit);
        bus_stop();
        if (hit) begin
            m_psi = data[7];
            if (data[6:0] == 7'h7C) begin
                m_off = 1'b1;
            end else begin
                m_off = 1'b0;
                if (addr[2:0] != 3'b110) m_a = data[6:0];
                if (addr[2:0] != 3'b010) m_b = data[6:0];
            end
        end
        push_state(req);
    endtask

    // monitor: pops the expected state and compares the outputs
    initial begin
        forever begin
            exp_t e;
            @(txn_done);
            wait_clks(1);
            e = exp_q.pop_front();
            chk(e.req, "code A", code_a, e.a);
            chk(e.req, "code B", code_b, e.b);
            chk(e.req, "power-state flag", psi_n, e.psi_n);
            chk(e.req, "off flag", voff, e.off);
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        wait_clks(4);
        rst = 1'b0;
        wait_clks(4);
        // R8 reset state in boot mode
        chk("R8", "oe after reset", oe, 1'b0);
        push_state("R8");

        // R8 boot code followed while power-good low
        boot = 2'b01; m_a = 7'd1; m_b = 7'd1;
        wait_clks(4);
        push_state("R8");

        // R8 bus ignored in boot mode
        send_txn(8'b11000100, 8'h35, "R8");

        // R8 boot input ignored once power-good is high
        pg = 1'b1; wait_clks(4);
        boot = 2'b11; wait_clks(4);
        push_state("R8");

        // R1 clocked bytes without a start
        put_byte(8'b11000100);
        ack_slot("R1", 1'b0);
        put_byte(8'h35);
        ack_slot("R1", 1'b0);
        bus_stop();
        push_state("R1");

        // R2 R6 both outputs
        send_txn(8'b11000100, 8'h35, "R2");
        // R3 A only, x bits = 11
        send_txn(8'b11011010, 8'hA2, "R3");
        // R3 B only, x bits = 01
        send_txn(8'b11001110, 8'h11, "R3");
        // R6 both with power-state flag high, x bits = 10
        send_txn(8'b11010100, 8'hC8, "R6");

        // R5 write bit set, and wrong top bits
        send_txn(8'b11000101, 8'h40, "R5");
        send_txn(8'b10000100, 8'h40, "R5");
        send_txn(8'b11000000, 8'h40, "R5");

        // R7 off command then a normal command
        send_txn(8'b11000100, 8'hFC, "R7");
        send_txn(8'b11000010, 8'h05, "R7");

        // R9 stop in the middle of the address byte
        bus_start();
        for (int i = 0; i < 4; i++) put_bit(1'b1);
        bus_stop();
        push_state("R9");

        // R9 stop in the middle of the data byte
        bus_start();
        put_byte(8'b11000100);
        ack_slot("R9", 1'b1);
        for (int i = 0; i < 5; i++) put_bit(1'b0);
        bus_stop();
        push_state("R9");

        // R9 start in the middle of a byte, then bytes without a fresh start
        bus_start();
        for (int i = 0; i < 3; i++) put_bit(1'b1);
        bus_start();
        put_byte(8'b11000100);
        ack_slot("R9", 1'b0);
        put_byte(8'h2A);
        ack_slot("R9", 1'b0);
        bus_stop();
        push_state("R9");

        // R2 recovery after aborts
        send_txn(8'b11011100, 8'h6B, "R2");

        wait_clks(10);
        chk("R9", "scoreboard drained", exp_q.size(), 0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule